// File: doc/BRIEF.md
# Multi-Select SPI Master Controller

This block is an SPI master for a host that works through a small word-wide register port. The host stores a byte in a transmit holding register. The engine moves that byte into its shifter and drives one of up to four active-low chip selects. It then clocks eight bits out and eight bits in, most significant bit first. The received byte lands in a receive holding register. The transmit holding register frees up as soon as its byte enters the shifter, so the host can queue the next byte while the current one is still on the wire.

Each chip select has its own 32-bit configuration word:

| Bits | Field |
|------|-------|
| [7:0] | clock divider |
| [8] | clock polarity |
| [9] | clock phase |
| [20:10] | setup delay |
| [31:21] | gap delay |

The setup delay runs from chip-select assertion to the first clock edge. The gap delay runs between words. Both delays count system-clock cycles.

The target chip select comes from one of two places. In fixed mode it is a field of the control register. In variable mode it comes from bits [9:8] of each transmit write. An overrun flag sticks until the host reads the status register. A single interrupt line is the OR of the status flags that the host has enabled.

Register word addresses:

| Address | Register | Access | Contents |
|---------|----------|--------|----------|
| 0 | control | write | bit0 enable, bit1 mode (0 fixed, 1 variable), bits[3:2] fixed chip-select code |
| 1 | interrupt enable | write | one enable bit per status flag, same positions as the status register |
| 2 | status | read | bit0 receive full, bit1 transmit empty, bit2 overrun |
| 3 | transmit | write | bits[7:0] data, bits[9:8] chip-select code |
| 4 | receive | read | bits[7:0] data |
| 8+n | configuration of chip select n | write | the configuration word above |

The host port has no back-pressure. A write always lands in the addressed register. A write to the transmit register while it is still full overwrites the byte that is waiting. Read data is combinational on the addressed register. A read's side effect (clearing a flag) takes place at the clock edge that ends the read cycle.

Top module: `spim_ctrl`

## Requirements
- R1: A byte written to the transmit register starts a transfer only while the enable bit is 1. A byte written while disabled waits, with every chip select high, until enable is set. The engine takes a byte only when the transmit holding register is full.
- R2: Each word is 8 bits, full duplex, most significant bit first. When phase is 0, data is captured on the leading clock edge. When phase is 1, data is captured on the trailing edge. The clock rests at the polarity bit. Each half clock period lasts divider/2 system cycles, and a divider below 2 acts as 2.
- R3: The chip select goes low one cycle after a transmit write to an idle, enabled block. Receive full rises 2+S+16H cycles after the write edge. H is the half period and S is the setup delay, with a setup value of 0 acting as H.
- R4: If a byte is waiting when a word's gap delay ends (a gap value of 0 acts as H), the next word runs without the host restarting it. When it targets the same chip select, that chip select stays low throughout.
- R5: With mode 0, every word uses the control register's chip-select code. Bits [9:8] of the transmit write are ignored.
- R6: With mode 1, bits [9:8] of each transmit write pick the chip select (code n drives cs_n[n] low). The word uses that chip select's own configuration.
- R7: A completed word is stored in the receive register if the overrun flag is clear. Overrun is set when a completed word finds the receive register still full. While overrun is set, completed words are discarded.
- R8: Reading status returns the flags and then clears overrun. Reading the receive register clears receive full.
- R9: When the gap after a word ends and no byte is waiting, all chip selects go high and the clock returns to its rest level.
- R10: irq is 1 exactly when some status flag and its enable bit are both 1.
- R11: After reset, all chip selects are high, the status reads 2 (only transmit empty), the receive register reads 0 and irq is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | system clock |
| rst_n | input | 1 | active-low asynchronous reset |
| host_wr | input | 1 | register write strobe |
| host_rd | input | 1 | register read strobe (clears flags at the edge) |
| host_addr | input | 4 | register word address |
| host_wdata | input | 32 | write data |
| host_rdata | output | 32 | read data, combinational on host_addr |
| sclk | output | 1 | serial clock |
| mosi | output | 1 | serial data out |
| miso | input | 1 | serial data in |
| cs_n | output | 4 | active-low chip selects |
| irq | output | 1 | interrupt request |

## Verification
The chip select falls one cycle after the transmit write edge. Receive full, and therefore irq, rises exactly 2+S+16H cycles after that edge. The bench counts falling clock edges from the write and checks irq one cycle before and at the due cycle, for both an explicit and a zero setup delay. A zero setup delay takes one half period. Transfers of unknown length (bursts, mode switches) are checked after waiting for the chip selects to return high. The checks then compare the bytes a bench-side slave captured, the chip-select pattern seen at each sample, and the register read-back. All outputs are sampled on the falling edge, half a cycle after the edge that updates them.

// File: rtl/spim_pkg.sv
package spim_pkg;
  localparam int BUS_W   = 32;
  localparam int DIV_W   = 8;
  localparam int DLY_W   = 11;
  localparam int A_CTRL  = 0;
  localparam int A_IEN   = 1;
  localparam int A_STAT  = 2;
  localparam int A_TXD   = 3;
  localparam int A_RXD   = 4;
  localparam int A_CFG   = 8;

  typedef struct packed {
    logic [DLY_W-1:0] gap;
    logic [DLY_W-1:0] setup;
    logic             cpha;
    logic             cpol;
    logic [DIV_W-1:0] div;
  } cs_cfg_t;

  typedef enum logic [1:0] {ST_IDLE, ST_SETUP, ST_XFER, ST_GAP} eng_st_t;

  function automatic logic [DLY_W-1:0] half_of(input logic [DIV_W-1:0] d);
    if (d < DIV_W'(2)) return DLY_W'(1);
    return DLY_W'(d >> 1);
  endfunction

  function automatic logic [DLY_W-1:0] dly_of(input logic [DLY_W-1:0] d,
                                              input logic [DLY_W-1:0] h);
    return (d == '0) ? h : d;
  endfunction
endpackage

// File: rtl/spim_regs.sv
module spim_regs import spim_pkg::*; #(
  parameter int NUM_CS = 4,
  parameter int CS_W   = 2,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [BUS_W-1:0]  host_wdata,
  output logic [BUS_W-1:0]  host_rdata,
  output logic              en,
  output logic              var_mode,
  output logic [CS_W-1:0]   fix_cs,
  output logic              tx_full,
  output logic [DATA_W-1:0] tx_word,
  output logic [CS_W-1:0]   tx_cs,
  output cs_cfg_t           cfg [NUM_CS],
  input  logic              tx_take,
  input  logic              rx_done,
  input  logic [DATA_W-1:0] rx_word,
  output logic              irq
);
  logic              rx_full, ovr;
  logic [DATA_W-1:0] rx_data;
  logic [2:0]        ien;
  logic [2:0]        status;

  wire wr_ctrl = host_wr && host_addr == ADDR_W'(A_CTRL);
  wire wr_ien  = host_wr && host_addr == ADDR_W'(A_IEN);
  wire wr_tx   = host_wr && host_addr == ADDR_W'(A_TXD);
  wire rd_stat = host_rd && host_addr == ADDR_W'(A_STAT);
  wire rd_rx   = host_rd && host_addr == ADDR_W'(A_RXD);

  assign status = {ovr, ~tx_full, rx_full};
  assign irq    = |(status & ien);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en <= 1'b0; var_mode <= 1'b0; fix_cs <= '0; ien <= '0;
      tx_full <= 1'b0; tx_word <= '0; tx_cs <= '0;
      rx_full <= 1'b0; ovr <= 1'b0; rx_data <= '0;
    end else begin
      if (wr_ctrl) begin
        en       <= host_wdata[0];
        var_mode <= host_wdata[1];
        fix_cs   <= host_wdata[2 +: CS_W];
      end
      if (wr_ien) ien <= host_wdata[2:0];
      if (tx_take) tx_full <= 1'b0;
      if (wr_tx) begin
        tx_full <= 1'b1;
        tx_word <= host_wdata[DATA_W-1:0];
        tx_cs   <= host_wdata[DATA_W +: CS_W];
      end
      if (rd_stat) ovr <= 1'b0;
      if (rd_rx) rx_full <= 1'b0;
      if (rx_done && !ovr) begin
        rx_data <= rx_word;
        if (rx_full && !rd_rx) ovr <= 1'b1;
        else rx_full <= 1'b1;
      end
    end
  end

  for (genvar i = 0; i < NUM_CS; i++) begin : g_cfg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cfg[i] <= '0;
      else if (host_wr && host_addr == ADDR_W'(A_CFG + i)) cfg[i] <= host_wdata;
    end
  end

  always_comb begin
    host_rdata = '0;
    case (host_addr)
      ADDR_W'(A_CTRL): host_rdata[2+CS_W-1:0] = {fix_cs, var_mode, en};
      ADDR_W'(A_IEN):  host_rdata[2:0] = ien;
      ADDR_W'(A_STAT): host_rdata[2:0] = status;
      ADDR_W'(A_RXD):  host_rdata[DATA_W-1:0] = rx_data;
      default: ;
    endcase
    for (int i = 0; i < NUM_CS; i++)
      if (host_addr == ADDR_W'(A_CFG + i)) host_rdata = cfg[i];
  end

  // R7: once overrun is up, completed words leave the receive register alone
  p_ovr_freeze_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ovr |=> $stable(rx_data));
  // R8: overrun only drops through a status read
  p_ovr_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr && !rd_stat) |=> ovr);
  // R1: the engine never takes from an empty holding register
  p_take_full_r1: assert property (@(posedge clk) disable iff (!rst_n)
    tx_take |-> tx_full);
endmodule

// File: rtl/spim_engine.sv
module spim_engine import spim_pkg::*; #(
  parameter int NUM_CS = 4,
  parameter int CS_W   = 2,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              var_mode,
  input  logic [CS_W-1:0]   fix_cs,
  input  logic              tx_full,
  input  logic [DATA_W-1:0] tx_word,
  input  logic [CS_W-1:0]   tx_cs,
  input  cs_cfg_t           cfg [NUM_CS],
  input  logic              miso,
  output logic              tx_take,
  output logic              rx_done,
  output logic [DATA_W-1:0] rx_word,
  output logic              sclk,
  output logic              mosi,
  output logic [NUM_CS-1:0] cs_n
);
  localparam int EDGES = 2 * DATA_W;
  localparam int EW    = $clog2(EDGES);
  localparam int BW    = $clog2(DATA_W);

  eng_st_t           st;
  logic [DLY_W-1:0]  cnt;
  logic [EW-1:0]     edge_n;
  logic [BW-1:0]     bitn;
  logic [DATA_W-1:0] txs, rxs;
  logic [CS_W-1:0]   cur_cs;
  cs_cfg_t           cur;
  logic              sclk_q, cs_act;

  logic [CS_W-1:0]   sel_cs;
  cs_cfg_t           new_cfg;
  logic [DLY_W-1:0]  new_half, half;
  logic              lead, smp, adv, last, tick;
  logic [DATA_W-1:0] rx_next;

  assign sel_cs   = var_mode ? tx_cs : fix_cs;
  assign new_cfg  = cfg[sel_cs];
  assign new_half = half_of(new_cfg.div);
  assign half     = half_of(cur.div);
  assign tick     = cnt == DLY_W'(1);
  assign tx_take  = en && tx_full && (st == ST_IDLE || (st == ST_GAP && tick));
  assign lead     = ~edge_n[0];
  assign smp      = lead ^ cur.cpha;
  assign adv      = cur.cpha ? (lead && edge_n != '0) : !lead;
  assign last     = edge_n == EW'(EDGES - 1);
  assign rx_next  = smp ? {rxs[DATA_W-2:0], miso} : rxs;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; cnt <= '0; edge_n <= '0; bitn <= '0;
      txs <= '0; rxs <= '0; cur_cs <= '0; cur <= '0;
      sclk_q <= 1'b0; cs_act <= 1'b0; rx_done <= 1'b0;
    end else begin
      rx_done <= 1'b0;
      case (st)
        ST_IDLE: begin
          sclk_q <= new_cfg.cpol;
          if (tx_take) begin
            cs_act <= 1'b1;
            st     <= ST_SETUP;
            cnt    <= dly_of(new_cfg.setup, new_half);
          end
        end
        ST_SETUP: begin
          if (tick) begin st <= ST_XFER; cnt <= half; end
          else cnt <= cnt - DLY_W'(1);
        end
        ST_XFER: begin
          if (tick) begin
            sclk_q <= ~sclk_q;
            rxs    <= rx_next;
            if (adv) bitn <= bitn + BW'(1);
            if (last) begin
              rx_done <= 1'b1;
              st      <= ST_GAP;
              cnt     <= dly_of(cur.gap, half);
            end else begin
              edge_n <= edge_n + EW'(1);
              cnt    <= half;
            end
          end else cnt <= cnt - DLY_W'(1);
        end
        ST_GAP: begin
          if (tick) begin
            if (tx_take) begin
              if (sel_cs == cur_cs) begin st <= ST_XFER; cnt <= new_half; end
              else begin st <= ST_SETUP; cnt <= dly_of(new_cfg.setup, new_half); end
            end else begin
              cs_act <= 1'b0;
              st     <= ST_IDLE;
            end
          end else cnt <= cnt - DLY_W'(1);
        end
        default: st <= ST_IDLE;
      endcase
      if (tx_take) begin
        cur_cs <= sel_cs;
        cur    <= new_cfg;
        txs    <= tx_word;
        rxs    <= '0;
        bitn   <= '0;
        edge_n <= '0;
        sclk_q <= new_cfg.cpol;
      end
    end
  end

  assign sclk    = sclk_q;
  assign mosi    = txs[BW'(DATA_W - 1) - bitn];
  assign rx_word = rxs;

  for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
    assign cs_n[i] = !(cs_act && cur_cs == CS_W'(i));
  end

  // R3: a setup count that expires hands over to shifting
  p_setup_exit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_SETUP && tick) |=> (st == ST_XFER));
  // R4: exactly one chip select is low while bits move
  p_one_cs_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_XFER) |-> ($countones(~cs_n) == 1));
  // R9: an idle engine with nothing to take leaves every select high
  p_idle_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE) |-> (&cs_n));
  // R2: the serial clock only moves during the shifting state or on a load
  p_clk_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_SETUP) |=> $stable(sclk));
endmodule

// File: rtl/spim_ctrl.sv
module spim_ctrl import spim_pkg::*; #(
  parameter int NUM_CS = 4,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [BUS_W-1:0]  host_wdata,
  output logic [BUS_W-1:0]  host_rdata,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic [NUM_CS-1:0] cs_n,
  output logic              irq
);
  localparam int CS_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1;

  logic              en, var_mode, tx_full, tx_take, rx_done;
  logic [CS_W-1:0]   fix_cs, tx_cs;
  logic [DATA_W-1:0] tx_word, rx_word;
  cs_cfg_t           cfg [NUM_CS];

  spim_regs #(.NUM_CS(NUM_CS), .CS_W(CS_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .en(en), .var_mode(var_mode), .fix_cs(fix_cs), .tx_full(tx_full),
    .tx_word(tx_word), .tx_cs(tx_cs), .cfg(cfg), .tx_take(tx_take),
    .rx_done(rx_done), .rx_word(rx_word), .irq(irq)
  );

  spim_engine #(.NUM_CS(NUM_CS), .CS_W(CS_W), .DATA_W(DATA_W)) u_eng (
    .clk(clk), .rst_n(rst_n), .en(en), .var_mode(var_mode), .fix_cs(fix_cs),
    .tx_full(tx_full), .tx_word(tx_word), .tx_cs(tx_cs), .cfg(cfg),
    .miso(miso), .tx_take(tx_take), .rx_done(rx_done), .rx_word(rx_word),
    .sclk(sclk), .mosi(mosi), .cs_n(cs_n)
  );
endmodule

// File: tb/sim_spim_ctrl.sv
module sim_spim_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr = 1'b0, host_rd = 1'b0;
  logic [3:0]  host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        sclk, mosi, miso, irq;
  logic [3:0]  cs_n;

  int total = 0, bad = 0;

  spim_ctrl u0 (.clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n), .irq(irq));

  always #(CLK_PERIOD/2) clk = ~clk;

  // bench-side slave: samples on the edge its mode calls for, presents next bit after
  logic       b_cpol = 1'b0, b_cpha = 1'b0;
  logic [15:0] s_bits = '0;
  logic [7:0] s_in = '0;
  logic [7:0] s_tx [8];
  logic [7:0] s_rx [8];
  logic [3:0] s_cs [8];
  int         cs0_rise = 0;

  assign miso = s_tx[s_bits[5:3]][3'd7 - s_bits[2:0]];

  always @(sclk) begin
    if (cs_n !== 4'hF && rst_n) begin
      if ((sclk != b_cpol) != b_cpha) begin
        s_in = {s_in[6:0], mosi};
        s_bits = s_bits + 16'd1;
        if (s_bits[2:0] == 3'd0) begin
          s_rx[s_bits[5:3] - 3'd1] = s_in;
          s_cs[s_bits[5:3] - 3'd1] = cs_n;
        end
      end
    end
  end

  always @(posedge cs_n[0]) cs0_rise++;

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk); host_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); host_rd = 1'b1; host_addr = a;
    #1 d = host_rdata;
    @(negedge clk); host_rd = 1'b0;
  endtask

  task automatic slave_reset(input logic [7:0] b0, input logic [7:0] b1, input logic [7:0] b2);
    s_bits = '0; s_tx[0] = b0; s_tx[1] = b1; s_tx[2] = b2;
    for (int i = 0; i < 8; i++) begin s_rx[i] = '0; s_cs[i] = 4'hF; end
  endtask

  task automatic wait_done(input string req);
    int n = 0;
    while (cs_n === 4'hF && n < 5000) begin @(negedge clk); n++; end
    while (cs_n !== 4'hF && n < 5000) begin @(negedge clk); n++; end
    if (n >= 5000) chk(req, 32'd0, 32'd1);
  endtask

  task automatic wait_tx_empty();
    logic [31:0] v;
    for (int n = 0; n < 2000; n++) begin
      rd(4'd2, v);
      if (v[1]) break;
    end
  endtask

  function automatic logic [31:0] cfgw(input int gap, input int setup, input logic cpha,
                                       input logic cpol, input logic [7:0] dv);
    return {11'(gap), 11'(setup), cpha, cpol, dv};
  endfunction

  // [25] polarity, [24] phase, [23:16] divider, [15:8] host byte, [7:0] slave byte
  localparam logic [25:0] VEC [5] = '{
    {1'b0, 1'b0, 8'd2, 8'hA5, 8'h3C},
    {1'b0, 1'b1, 8'd4, 8'h81, 8'hC7},
    {1'b1, 1'b0, 8'd3, 8'h7E, 8'h01},
    {1'b1, 1'b1, 8'd6, 8'h0F, 8'hF0},
    {1'b0, 1'b0, 8'd0, 8'h55, 8'hAA}
  };

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL R1 watchdog expired actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] v;
    for (int i = 0; i < 8; i++) s_tx[i] = '0;
    slave_reset(8'h00, 8'h00, 8'h00);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 reset state
    chk("R11 cs_n", {28'd0, cs_n}, 32'hF);
    chk("R11 irq", {31'd0, irq}, 32'd0);
    rd(4'd2, v); chk("R11 status", v, 32'd2);
    rd(4'd4, v); chk("R11 rx", v, 32'd0);

    // R2 table of modes on chip select 0, fixed mode
    for (int k = 0; k < 5; k++) begin
      b_cpol = VEC[k][25]; b_cpha = VEC[k][24];
      wr(4'd8, cfgw(0, 0, VEC[k][24], VEC[k][25], VEC[k][23:16]));
      wr(4'd0, 32'h1);
      slave_reset(VEC[k][7:0], 8'h00, 8'h00);
      wr(4'd3, {24'd0, VEC[k][15:8]});
      wait_done("R2 transfer ends");
      chk("R2 mosi byte msb first", {24'd0, s_rx[0]}, {24'd0, VEC[k][15:8]});
      chk("R5 fixed cs0", {28'd0, s_cs[0]}, 32'hE);
      chk("R9 sclk at rest", {31'd0, sclk}, {31'd0, VEC[k][25]});
      rd(4'd4, v); chk("R2 miso byte", v, {24'd0, VEC[k][7:0]});
    end

    // R3 exact timing: setup 5, divider 4 (half 2) -> irq at 39
    b_cpol = 1'b0; b_cpha = 1'b0;
    wr(4'd1, 32'h1);
    wr(4'd8, cfgw(0, 5, 1'b0, 1'b0, 8'd4));
    slave_reset(8'h96, 8'h00, 8'h00);
    wr(4'd3, 32'h0C);
    chk("R3 cs before load", {28'd0, cs_n}, 32'hF);
    @(negedge clk);
    chk("R3 cs one cycle after write", {28'd0, cs_n}, 32'hE);
    repeat (37) @(negedge clk);
    chk("R3 rx not yet full", {31'd0, irq}, 32'd0);
    @(negedge clk);
    chk("R3 rx full on time", {31'd0, irq}, 32'd1);
    wait_done("R3 end");
    rd(4'd4, v); chk("R3 rx data", v, 32'h96);

    // R3 zero setup acts as one half period -> irq at 36
    wr(4'd8, cfgw(0, 0, 1'b0, 1'b0, 8'd4));
    slave_reset(8'h5D, 8'h00, 8'h00);
    wr(4'd3, 32'h33);
    repeat (35) @(negedge clk);
    chk("R3 zero setup not yet", {31'd0, irq}, 32'd0);
    @(negedge clk);
    chk("R3 zero setup on time", {31'd0, irq}, 32'd1);
    wait_done("R3 end2");
    rd(4'd4, v);

    // R4 burst with R7 overrun and R8 clearing
    wr(4'd1, 32'h0);
    wr(4'd8, cfgw(3, 0, 1'b0, 1'b0, 8'd2));
    slave_reset(8'h11, 8'h22, 8'h33);
    cs0_rise = 0;
    wr(4'd3, 32'h5A);
    wait_tx_empty();
    wr(4'd3, 32'hC1);
    wait_tx_empty();
    wr(4'd3, 32'h7B);
    wait_done("R4 burst");
    chk("R4 cs held across burst", cs0_rise, 32'd1);
    chk("R4 word0", {24'd0, s_rx[0]}, 32'h5A);
    chk("R4 word1", {24'd0, s_rx[1]}, 32'hC1);
    chk("R4 word2", {24'd0, s_rx[2]}, 32'h7B);
    rd(4'd2, v); chk("R7 overrun status", v, 32'h7);
    rd(4'd4, v); chk("R7 rx keeps word that overran", v, 32'h22);
    rd(4'd2, v); chk("R8 flags cleared", v, 32'h2);

    // R6 variable mode: code 2 then code 1 back to back
    wr(4'd10, cfgw(0, 3, 1'b0, 1'b0, 8'd4));
    wr(4'd9, cfgw(0, 0, 1'b0, 1'b0, 8'd2));
    wr(4'd0, 32'h3);
    slave_reset(8'hE4, 8'h19, 8'h00);
    wr(4'd3, 32'h2C3);
    wait_tx_empty();
    wr(4'd3, 32'h13C);
    wait_done("R6 burst");
    chk("R6 word0 on cs2", {28'd0, s_cs[0]}, 32'hB);
    chk("R6 word1 on cs1", {28'd0, s_cs[1]}, 32'hD);
    chk("R6 word0 data", {24'd0, s_rx[0]}, 32'hC3);
    chk("R6 word1 data", {24'd0, s_rx[1]}, 32'h3C);
    rd(4'd2, v); rd(4'd4, v);
    chk("R7 second word made overrun", v, 32'h19);
    rd(4'd2, v);

    // R5 fixed mode ignores the code field
    wr(4'd11, cfgw(0, 0, 1'b0, 1'b0, 8'd2));
    wr(4'd0, 32'hD);
    slave_reset(8'h6E, 8'h00, 8'h00);
    wr(4'd3, 32'h196);
    @(negedge clk); @(negedge clk);
    chk("R5 cs1 untouched", {31'd0, cs_n[1]}, 32'd1);
    wait_done("R5 end");
    chk("R5 fixed cs3", {28'd0, s_cs[0]}, 32'h7);
    rd(4'd4, v); chk("R5 rx data", v, 32'h6E);

    // R1 disabled holds the byte; R10 interrupt masking
    wr(4'd1, 32'h2);
    @(negedge clk);
    chk("R10 tx empty irq", {31'd0, irq}, 32'd1);
    wr(4'd0, 32'h0);
    wr(4'd8, cfgw(0, 0, 1'b0, 1'b0, 8'd2));
    slave_reset(8'hB2, 8'h00, 8'h00);
    wr(4'd3, 32'hA7);
    chk("R10 irq drops when tx full", {31'd0, irq}, 32'd0);
    repeat (40) @(negedge clk);
    chk("R1 no select while disabled", {28'd0, cs_n}, 32'hF);
    rd(4'd2, v); chk("R1 byte still waiting", v, 32'h0);
    wr(4'd0, 32'h1);
    wait_done("R1 start after enable");
    chk("R1 byte sent", {24'd0, s_rx[0]}, 32'hA7);
    chk("R10 irq back", {31'd0, irq}, 32'd1);
    wr(4'd1, 32'h0);
    chk("R10 masked", {31'd0, irq}, 32'd0);
    rd(4'd4, v); chk("R1 rx data", v, 32'hB2);

    summary();
    $finish;
  end
endmodule